// File: doc/BRIEF.md
# Send Descriptor Ring Producer

This block turns one packet send request into a run of 128-bit descriptors in a circular descriptor queue. A request carries a header buffer (address plus length in dwords) and up to `MAX_FRAGS` payload fragments (address plus byte length). The block writes one descriptor per cycle into consecutive ring slots. It stamps each descriptor with a 2-bit generation count that advances every time the ring wraps. It also keeps a running buffer dword offset across the packet and marks the opening and closing descriptors with their own flags.

Before writing anything, the block compares the descriptors the packet needs with the free slots between its tail and the consumer's head index. A packet that does not fit is refused with a busy pulse and leaves the ring untouched. Once the last descriptor of an accepted packet has been written, the block publishes the new tail on a one-cycle strobe, together with the first and final ring indexes of the packet, so the engine never sees a partial packet. Fragments of zero length are flagged as errors and produce no descriptor.

Top module: `desc_ring_producer`

## Requirements
- R1: After reset, `reqReady` is 1, `descWrEn`, `tailUpd`, `submitValid`, `reqBusy` and `fragErr` are 0, and `tailIdx` and `curGen` are 0.
- R2: The opening descriptor of a packet carries the header address and uses the header dword count in word0[26:16], offset 0 in word0[10:0], and FIRST in word0[12]. Address bits 31:2 go to word0[63:34], word0[33:32] is 0, and word1[15:0] holds address bits 47:32 with the rest of word1 at 0.
- R3: Each nonzero payload fragment, in ascending fragment order, yields one descriptor. Its dword count is the byte length rounded up to whole dwords (modulo 2048). Its offset is the header dword count plus all earlier payload dword counts (modulo 2048). FIRST is clear. The address is packed as in R2.
- R4: When `useLargeBuf` is 1, word0[14] is set in every descriptor of the packet; otherwise it is clear in all of them.
- R5: Only the final descriptor of a packet has LAST in word0[11]. Head-writeback word0[13] and interrupt word0[15] appear only on that descriptor, and only when `wantHeadWb` or `wantIntr` is set.
- R6: Descriptors are written one per cycle to consecutive indexes starting at the previous tail, beginning the cycle after acceptance. The index wraps from DEPTH-1 to 0.
- R7: word0[31:30] carries the generation count. It increments modulo 4 after the descriptor at index DEPTH-1 is written, and `curGen` shows the current count.
- R8: Free slots are DEPTH-1-((tail-ringHead) mod DEPTH). A request needing more descriptors than that gives a one-cycle `reqBusy` the cycle after the request and writes nothing, and `tailIdx` keeps its value.
- R9: `tailUpd` pulses for one cycle, the cycle after the final descriptor write, with `tailIdx` equal to the new tail; `tailIdx` changes at no other time.
- R10: `submitValid` pulses with `tailUpd`, with `submitStart` the opening descriptor's index and `submitEnd` the final descriptor's index.
- R11: A fragment below `fragCount` with byte length 0 raises `fragErr` for one cycle, the cycle after the request. It produces no descriptor and adds nothing to the offset.
- R12: Fragments at or above `fragCount` are ignored: no descriptor, no offset contribution, no `fragErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken while `reqReady` is 1 |
| reqReady | output | 1 | Idle and able to take a request |
| hdrAddr | input | 48 | Header buffer address |
| hdrDwords | input | 11 | Header length in dwords |
| fragCount | input | $clog2(MAX_FRAGS+1) | Number of payload fragments used |
| fragAddrs | input | MAX_FRAGS*48 | Fragment addresses, fragment i at bits i*48 upward |
| fragBytes | input | MAX_FRAGS*LENW | Fragment byte lengths, fragment i at bits i*LENW upward |
| useLargeBuf | input | 1 | Select the large send buffer for the packet |
| wantHeadWb | input | 1 | Request head writeback on the final descriptor |
| wantIntr | input | 1 | Request an interrupt on the final descriptor |
| ringHead | input | $clog2(DEPTH) | Consumer head index |
| descWrEn | output | 1 | Descriptor write strobe |
| descWrIdx | output | $clog2(DEPTH) | Ring index being written |
| descWord0 | output | 64 | Descriptor word 0 |
| descWord1 | output | 64 | Descriptor word 1 |
| tailUpd | output | 1 | New tail publish strobe |
| tailIdx | output | $clog2(DEPTH) | Last published tail |
| curGen | output | 2 | Current generation count |
| submitValid | output | 1 | Accepted-packet strobe |
| submitStart | output | $clog2(DEPTH) | Index of the packet's opening descriptor |
| submitEnd | output | $clog2(DEPTH) | Index of the packet's final descriptor |
| reqBusy | output | 1 | Request refused for lack of space |
| fragErr | output | 1 | Zero-length fragment seen in the request |

## Verification
`reqBusy` and `fragErr` are due one cycle after the request edge, so the driver samples them at the first falling edge after it drops `reqValid`. For an accepted packet of n descriptors, descriptor k shows on `descWrEn` k+1 cycles after acceptance, and `tailUpd` and `submitValid` appear n+1 cycles after it. The driver pushes the expected descriptors and publish records into queues, and a monitor pops one on every falling edge at which the matching strobe is high. Any extra, missing or reordered output therefore shows up as a mismatch or as a non-empty queue at the end.

// File: rtl/descq_pkg.sv
package descq_pkg;
  localparam int ADDR_W = 48;
  localparam int DCNT_W = 11;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_EMIT    = 2'd1,
    ST_PUBLISH = 2'd2
  } ctlState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic start;    // latch request, snapshot tail
    logic emit;     // write one descriptor this cycle
    logic last;     // the descriptor being written closes the packet
    logic publish;  // expose new tail and submission record
  } ctlStrobe_t;
endpackage

// File: rtl/descq_ctrl.sv
module descq_ctrl
  import descq_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int MAX_FRAGS = 4,
  parameter int LENW      = 12,
  localparam int IDXW     = $clog2(DEPTH),
  localparam int CW       = $clog2(MAX_FRAGS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reqValid,
  input  logic [CW-1:0]             fragCount,
  input  logic [MAX_FRAGS*LENW-1:0] fragBytes,
  input  logic [IDXW-1:0]           ringHead,
  input  logic [IDXW-1:0]           tailNow,
  output logic                      reqReady,
  output ctlStrobe_t                strb,
  output logic                      reqBusy,
  output logic                      fragErr
);
  localparam int SW = IDXW + 1;

  ctlState_e stateQ;
  logic [SW-1:0] remainQ;
  logic [MAX_FRAGS-1:0] liveMask, zeroMask;
  logic [SW-1:0] needed, usedSlots, freeSlots;
  logic fits, takeReq;

  always_comb begin
    liveMask = '0;
    zeroMask = '0;
    needed   = SW'(1);
    for (int i = 0; i < MAX_FRAGS; i++) begin
      if (fragCount > CW'(i)) begin
        if (fragBytes[i*LENW +: LENW] == '0) zeroMask[i] = 1'b1;
        else begin
          liveMask[i] = 1'b1;
          needed = needed + SW'(1);
        end
      end
    end
  end

  always_comb begin
    if (tailNow >= ringHead) usedSlots = SW'(tailNow) - SW'(ringHead);
    else                     usedSlots = SW'(tailNow) + SW'(DEPTH) - SW'(ringHead);
    freeSlots = SW'(DEPTH - 1) - usedSlots;
  end

  assign fits     = (needed <= freeSlots);
  assign takeReq  = (stateQ == ST_IDLE) && reqValid;
  assign reqReady = (stateQ == ST_IDLE);

  always_comb begin
    strb.start   = takeReq && fits;
    strb.emit    = (stateQ == ST_EMIT);
    strb.last    = (stateQ == ST_EMIT) && (remainQ == SW'(1));
    strb.publish = (stateQ == ST_PUBLISH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ  <= ST_IDLE;
      remainQ <= '0;
      reqBusy <= 1'b0;
      fragErr <= 1'b0;
    end else begin
      reqBusy <= takeReq && !fits;
      fragErr <= takeReq && (|zeroMask);
      case (stateQ)
        ST_IDLE: if (takeReq && fits) begin
          stateQ  <= ST_EMIT;
          remainQ <= needed;
        end
        ST_EMIT: begin
          remainQ <= remainQ - SW'(1);
          if (remainQ == SW'(1)) stateQ <= ST_PUBLISH;
        end
        ST_PUBLISH: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R8
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqBusy |-> (stateQ == ST_IDLE));

  // R6
  emit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_EMIT) |-> (remainQ != '0));
endmodule

// File: rtl/descq_datapath.sv
module descq_datapath
  import descq_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int MAX_FRAGS = 4,
  parameter int LENW      = 12,
  localparam int IDXW     = $clog2(DEPTH),
  localparam int CW       = $clog2(MAX_FRAGS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctlStrobe_t                  strb,
  input  logic [ADDR_W-1:0]           hdrAddr,
  input  logic [DCNT_W-1:0]           hdrDwords,
  input  logic [CW-1:0]               fragCount,
  input  logic [MAX_FRAGS*ADDR_W-1:0] fragAddrs,
  input  logic [MAX_FRAGS*LENW-1:0]   fragBytes,
  input  logic                        useLargeBuf,
  input  logic                        wantHeadWb,
  input  logic                        wantIntr,
  output logic [IDXW-1:0]             tailNow,
  output logic                        descWrEn,
  output logic [IDXW-1:0]             descWrIdx,
  output logic [63:0]                 descWord0,
  output logic [63:0]                 descWord1,
  output logic                        tailUpd,
  output logic [IDXW-1:0]             tailIdx,
  output logic [1:0]                  curGen,
  output logic                        submitValid,
  output logic [IDXW-1:0]             submitStart,
  output logic [IDXW-1:0]             submitEnd
);
  localparam int FW = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1;

  logic [ADDR_W-1:0]           hdrAddrQ;
  logic [DCNT_W-1:0]           hdrDwQ;
  logic [MAX_FRAGS*ADDR_W-1:0] fragAddrQ;
  logic [MAX_FRAGS*LENW-1:0]   fragBytesQ;
  logic [MAX_FRAGS-1:0]        pendMaskQ;
  logic                        largeQ, headWbQ, intrQ, hdrPendQ;
  logic [DCNT_W-1:0]           offsetQ;
  logic [IDXW-1:0]             tailQ, startIdxQ, lastIdxQ;
  logic [1:0]                  genQ;

  logic [MAX_FRAGS-1:0] liveMask;
  logic [FW-1:0]        selIdx;
  logic [LENW-1:0]      selBytes;
  logic [LENW:0]        roundUp;
  logic [ADDR_W-1:0]    curAddr;
  logic [DCNT_W-1:0]    curCnt, curOff;
  logic                 curFirst, wrapNow;
  logic [IDXW-1:0]      tailNext;

  // nonzero fragments inside the requested count
  always_comb begin
    liveMask = '0;
    for (int i = 0; i < MAX_FRAGS; i++)
      liveMask[i] = (fragCount > CW'(i)) && (fragBytes[i*LENW +: LENW] != '0);
  end

  // lowest pending fragment wins
  always_comb begin
    selIdx = '0;
    for (int i = MAX_FRAGS - 1; i >= 0; i--)
      if (pendMaskQ[i]) selIdx = FW'(i);
  end

  always_comb begin
    selBytes = fragBytesQ[selIdx*LENW +: LENW];
    roundUp  = {1'b0, selBytes} + (LENW+1)'(3);
    if (hdrPendQ) begin
      curAddr  = hdrAddrQ;
      curCnt   = hdrDwQ;
      curOff   = '0;
      curFirst = 1'b1;
    end else begin
      curAddr  = fragAddrQ[selIdx*ADDR_W +: ADDR_W];
      curCnt   = DCNT_W'(roundUp >> 2);
      curOff   = offsetQ;
      curFirst = 1'b0;
    end
  end

  assign wrapNow  = (tailQ == IDXW'(DEPTH - 1));
  assign tailNext = wrapNow ? '0 : tailQ + IDXW'(1);
  assign tailNow  = tailQ;
  assign curGen   = genQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdrAddrQ    <= '0;
      hdrDwQ      <= '0;
      fragAddrQ   <= '0;
      fragBytesQ  <= '0;
      pendMaskQ   <= '0;
      largeQ      <= 1'b0;
      headWbQ     <= 1'b0;
      intrQ       <= 1'b0;
      hdrPendQ    <= 1'b0;
      offsetQ     <= '0;
      tailQ       <= '0;
      genQ        <= '0;
      startIdxQ   <= '0;
      lastIdxQ    <= '0;
      descWrEn    <= 1'b0;
      descWrIdx   <= '0;
      descWord0   <= '0;
      descWord1   <= '0;
      tailUpd     <= 1'b0;
      tailIdx     <= '0;
      submitValid <= 1'b0;
      submitStart <= '0;
      submitEnd   <= '0;
    end else begin
      descWrEn    <= 1'b0;
      tailUpd     <= 1'b0;
      submitValid <= 1'b0;

      if (strb.start) begin
        hdrAddrQ   <= hdrAddr;
        hdrDwQ     <= hdrDwords;
        fragAddrQ  <= fragAddrs;
        fragBytesQ <= fragBytes;
        pendMaskQ  <= liveMask;
        largeQ     <= useLargeBuf;
        headWbQ    <= wantHeadWb;
        intrQ      <= wantIntr;
        hdrPendQ   <= 1'b1;
        offsetQ    <= hdrDwords;
        startIdxQ  <= tailQ;
      end

      if (strb.emit) begin
        descWrEn  <= 1'b1;
        descWrIdx <= tailQ;
        descWord0 <= {curAddr[31:2], 2'b00, genQ, 3'b000, curCnt,
                      strb.last & intrQ, largeQ, strb.last & headWbQ,
                      curFirst, strb.last, curOff};
        descWord1 <= {{(64-(ADDR_W-32)){1'b0}}, curAddr[ADDR_W-1:32]};
        tailQ     <= tailNext;
        if (wrapNow) genQ <= genQ + 2'd1;
        if (hdrPendQ) hdrPendQ <= 1'b0;
        else begin
          pendMaskQ[selIdx] <= 1'b0;
          offsetQ <= offsetQ + curCnt;
        end
        if (strb.last) lastIdxQ <= tailQ;
      end

      if (strb.publish) begin
        tailUpd     <= 1'b1;
        tailIdx     <= tailQ;
        submitValid <= 1'b1;
        submitStart <= startIdxQ;
        submitEnd   <= lastIdxQ;
      end
    end
  end

  // R6
  tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    descWrEn |-> (tailQ == ((descWrIdx == IDXW'(DEPTH - 1)) ? '0 : descWrIdx + IDXW'(1))));

  // R7
  gen_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (descWrEn && descWrIdx == IDXW'(DEPTH - 1)) |-> (genQ == descWord0[31:30] + 2'd1));

  // R9
  publish_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tailUpd |-> ($past(descWrEn) && $past(descWord0[11])));

  // R2
  first_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (descWrEn && descWord0[12]) |-> !$past(descWrEn));

  // R10
  submit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    submitValid |-> (submitEnd == $past(descWrIdx)));
endmodule

// File: rtl/desc_ring_producer.sv
module desc_ring_producer
  import descq_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int MAX_FRAGS = 4,
  parameter int LENW      = 12,
  localparam int IDXW     = $clog2(DEPTH),
  localparam int CW       = $clog2(MAX_FRAGS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [ADDR_W-1:0]           hdrAddr,
  input  logic [DCNT_W-1:0]           hdrDwords,
  input  logic [CW-1:0]               fragCount,
  input  logic [MAX_FRAGS*ADDR_W-1:0] fragAddrs,
  input  logic [MAX_FRAGS*LENW-1:0]   fragBytes,
  input  logic                        useLargeBuf,
  input  logic                        wantHeadWb,
  input  logic                        wantIntr,
  input  logic [IDXW-1:0]             ringHead,
  output logic                        descWrEn,
  output logic [IDXW-1:0]             descWrIdx,
  output logic [63:0]                 descWord0,
  output logic [63:0]                 descWord1,
  output logic                        tailUpd,
  output logic [IDXW-1:0]             tailIdx,
  output logic [1:0]                  curGen,
  output logic                        submitValid,
  output logic [IDXW-1:0]             submitStart,
  output logic [IDXW-1:0]             submitEnd,
  output logic                        reqBusy,
  output logic                        fragErr
);
  ctlStrobe_t     strb;
  logic [IDXW-1:0] tailNow;

  descq_ctrl #(.DEPTH(DEPTH), .MAX_FRAGS(MAX_FRAGS), .LENW(LENW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .fragCount(fragCount),
    .fragBytes(fragBytes), .ringHead(ringHead), .tailNow(tailNow),
    .reqReady(reqReady), .strb(strb), .reqBusy(reqBusy), .fragErr(fragErr)
  );

  descq_datapath #(.DEPTH(DEPTH), .MAX_FRAGS(MAX_FRAGS), .LENW(LENW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .hdrAddr(hdrAddr),
    .hdrDwords(hdrDwords), .fragCount(fragCount), .fragAddrs(fragAddrs),
    .fragBytes(fragBytes), .useLargeBuf(useLargeBuf), .wantHeadWb(wantHeadWb),
    .wantIntr(wantIntr), .tailNow(tailNow), .descWrEn(descWrEn),
    .descWrIdx(descWrIdx), .descWord0(descWord0), .descWord1(descWord1),
    .tailUpd(tailUpd), .tailIdx(tailIdx), .curGen(curGen),
    .submitValid(submitValid), .submitStart(submitStart), .submitEnd(submitEnd)
  );

  // R8
  busy_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqBusy |=> !descWrEn);

  // R9
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tailUpd |-> $stable(tailIdx));
endmodule

// File: tb/desc_ring_producer_test.sv
`timescale 1ns/1ps
module desc_ring_producer_test;
  localparam int DEPTH = 256;
  localparam int MAXF  = 4;
  localparam int LENW  = 12;
  localparam int IDXW  = $clog2(DEPTH);
  localparam int CW    = $clog2(MAXF + 1);
  localparam int EW    = IDXW + 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [47:0] hdrAddr = '0;
  logic [10:0] hdrDwords = '0;
  logic [CW-1:0] fragCount = '0;
  logic [MAXF*48-1:0] fragAddrs = '0;
  logic [MAXF*LENW-1:0] fragBytes = '0;
  logic useLargeBuf = 1'b0, wantHeadWb = 1'b0, wantIntr = 1'b0;
  logic [IDXW-1:0] ringHead = '0;
  logic descWrEn, tailUpd, submitValid, reqBusy, fragErr;
  logic [IDXW-1:0] descWrIdx, tailIdx, submitStart, submitEnd;
  logic [63:0] descWord0, descWord1;
  logic [1:0] curGen;

  always #5 clk = ~clk;

  desc_ring_producer #(.DEPTH(DEPTH), .MAX_FRAGS(MAXF), .LENW(LENW)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .hdrAddr(hdrAddr), .hdrDwords(hdrDwords), .fragCount(fragCount),
    .fragAddrs(fragAddrs), .fragBytes(fragBytes), .useLargeBuf(useLargeBuf),
    .wantHeadWb(wantHeadWb), .wantIntr(wantIntr), .ringHead(ringHead),
    .descWrEn(descWrEn), .descWrIdx(descWrIdx), .descWord0(descWord0),
    .descWord1(descWord1), .tailUpd(tailUpd), .tailIdx(tailIdx),
    .curGen(curGen), .submitValid(submitValid), .submitStart(submitStart),
    .submitEnd(submitEnd), .reqBusy(reqBusy), .fragErr(fragErr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [EW-1:0] expDesc[$];
  string         expTag[$];
  logic [EW-1:0] expPub[$];

  int mTail = 0;
  int mGen = 0;
  int lastWritten = 0;
  logic [47:0] sFragAddr[MAXF];
  int          sFragBytes[MAXF];

  task automatic chk(input bit ok, input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected descriptor from the requirement text (R2..R7)
  task automatic pushDesc(input logic [47:0] a, input logic [10:0] cnt, input logic [10:0] off,
                          input bit first, input bit last, input bit lg, input bit hw,
                          input bit it, input string tag);
    logic [63:0] w0, w1;
    w0 = '0;
    w0[63:34] = a[31:2];
    w0[31:30] = 2'(mGen);
    w0[26:16] = cnt;
    w0[15] = last & it;
    w0[14] = lg;
    w0[13] = last & hw;
    w0[12] = first;
    w0[11] = last;
    w0[10:0] = off;
    w1 = {48'b0, a[47:32]};
    expDesc.push_back({IDXW'(mTail), w0, w1});
    expTag.push_back(tag);
    lastWritten = mTail;
    if (mTail == DEPTH - 1) begin
      mTail = 0;
      mGen = (mGen + 1) % 4;
    end else mTail = mTail + 1;
  endtask

  task automatic sendPkt(input logic [47:0] ha, input logic [10:0] hd, input int nf,
                         input bit lg, input bit hw, input bit it, input string rq);
    int needed, zeros, used, freeN, k, startT;
    bit expBusy;
    logic [10:0] off, cnt;
    needed = 1;
    zeros = 0;
    for (int i = 0; i < nf; i++)
      if (sFragBytes[i] == 0) zeros++; else needed++;
    used = (mTail - int'(ringHead) + DEPTH) % DEPTH;
    freeN = DEPTH - 1 - used;
    expBusy = needed > freeN;
    startT = mTail;
    if (!expBusy) begin
      pushDesc(ha, hd, 11'd0, 1'b1, needed == 1, lg, hw, it, {rq, " R2"});
      off = hd;
      k = 1;
      for (int i = 0; i < nf; i++) begin
        if (sFragBytes[i] != 0) begin
          cnt = 11'((sFragBytes[i] + 3) >> 2);
          k++;
          pushDesc(sFragAddr[i], cnt, off, 1'b0, k == needed, lg, hw, it, {rq, " R3"});
          off = off + cnt;
        end
      end
      expPub.push_back(EW'({IDXW'(mTail), IDXW'(startT), IDXW'(lastWritten)}));
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    hdrAddr = ha;
    hdrDwords = hd;
    fragCount = CW'(nf);
    for (int i = 0; i < MAXF; i++) begin
      fragAddrs[i*48 +: 48] = sFragAddr[i];
      fragBytes[i*LENW +: LENW] = LENW'(sFragBytes[i]);
    end
    useLargeBuf = lg;
    wantHeadWb = hw;
    wantIntr = it;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqBusy == expBusy, {rq, " R8 busy"}, EW'(reqBusy), EW'(expBusy));
    chk(fragErr == (zeros > 0), {rq, " R11 fragErr"}, EW'(fragErr), EW'(zeros > 0));
    if (expBusy)
      chk(tailIdx == IDXW'(mTail), {rq, " R8 tail kept"}, EW'(tailIdx), EW'(mTail));
    while (!reqReady) @(negedge clk);
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (descWrEn) begin
        if (expDesc.size() == 0)
          chk(1'b0, "R6 unexpected descriptor", {descWrIdx, descWord0, descWord1}, '0);
        else begin
          logic [EW-1:0] e;
          string t;
          e = expDesc.pop_front();
          t = expTag.pop_front();
          chk({descWrIdx, descWord0, descWord1} == e, {t, " R4 R5 R6 R7 descriptor"},
              {descWrIdx, descWord0, descWord1}, e);
        end
      end
      if (tailUpd || submitValid) begin
        logic [EW-1:0] a;
        a = EW'({tailIdx, submitStart, submitEnd});
        if (expPub.size() == 0 || !(tailUpd && submitValid))
          chk(1'b0, "R9 R10 unexpected publish", a, '0);
        else begin
          logic [EW-1:0] e;
          e = expPub.pop_front();
          chk(a == e, "R9 R10 publish", a, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MAXF; i++) begin
      sFragAddr[i] = '0;
      sFragBytes[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1 ready", EW'(reqReady), EW'(1));
    chk({descWrEn, tailUpd, submitValid, reqBusy, fragErr} == '0, "R1 strobes",
        EW'({descWrEn, tailUpd, submitValid, reqBusy, fragErr}), '0);
    chk({tailIdx, curGen} == '0, "R1 tail gen", EW'({tailIdx, curGen}), '0);

    // R2 R5: header only, head writeback + interrupt, unaligned address
    sendPkt(48'hABCD_1234_5677, 11'd5, 0, 1'b0, 1'b1, 1'b1, "hdr-only");

    // R3 R4 R5: three fragments, large buffer, odd lengths
    sFragAddr[0] = 48'h0000_1000_0040; sFragBytes[0] = 64;
    sFragAddr[1] = 48'h7FFF_2222_0103; sFragBytes[1] = 5;
    sFragAddr[2] = 48'h0001_3333_0200; sFragBytes[2] = 1000;
    sendPkt(48'h0012_0000_0010, 11'd16, 3, 1'b1, 1'b0, 1'b1, "three-frag");

    // R11: zero-length fragment in the middle and at the end
    sFragBytes[1] = 0;
    sFragAddr[3] = 48'h0002_4444_0400; sFragBytes[3] = 0;
    sendPkt(48'h0000_0000_0800, 11'd3, 4, 1'b0, 1'b1, 1'b0, "zero-frag");

    // R12: fragments beyond count ignored (one of them zero)
    sFragBytes[1] = 12; sFragBytes[2] = 77; sFragBytes[3] = 0;
    sendPkt(48'h0000_5555_0000, 11'd2, 2, 1'b1, 1'b1, 1'b1, "count-limit");

    // R8: free-space boundary
    ringHead = IDXW'((mTail + 3) % DEPTH);
    sFragBytes[0] = 8; sFragBytes[1] = 8; sFragBytes[2] = 8;
    sendPkt(48'h0000_6666_0000, 11'd1, 2, 1'b0, 1'b0, 1'b0, "busy-need3");
    sendPkt(48'h0000_6666_0100, 11'd1, 1, 1'b0, 1'b0, 1'b0, "fit-need2");
    sendPkt(48'h0000_6666_0200, 11'd1, 0, 1'b0, 1'b0, 1'b0, "busy-full");
    ringHead = IDXW'(mTail);

    // R6 R7: run past two wraps, with packets straddling index DEPTH-1
    for (int k = 0; k < 140; k++) begin
      for (int i = 0; i < MAXF; i++) begin
        sFragAddr[i] = 48'(k * 4096 + i * 256 + 3);
        sFragBytes[i] = 1 + ((k * 37 + i * 11) % 4000);
      end
      ringHead = IDXW'(mTail);
      sendPkt(48'(k * 64), 11'(k % 40), 4, k[0], k[1], k[2], "wrap");
    end

    repeat (5) @(negedge clk);
    chk(expDesc.size() == 0, "R6 all descriptors seen", EW'(expDesc.size()), '0);
    chk(expPub.size() == 0, "R9 all publishes seen", EW'(expPub.size()), '0);
    chk(curGen == 2'(mGen), "R7 generation", EW'(curGen), EW'(mGen));
    chk(tailIdx == IDXW'(mTail), "R9 final tail", EW'(tailIdx), EW'(mTail));
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule